// File: doc/BRIEF.md
# Multi-Format Audio Serial Port Master

This block is the master side of a two-channel audio serial link. From one system clock it generates a bit clock, a frame clock and a master clock. It shifts a left/right pair of 24-bit samples out on a serial output and captures a pair from a serial input. Five framing formats are supported: I2S, left-justified, right-justified, long frame sync and short frame sync. A frame is 32 or 64 bit-clock periods long.

The bit clock comes from a programmable divider. Its half-period is a whole number of system cycles, with a floor of three. Transmit pairs enter through a valid/ready handshake that is offered once per frame. Received pairs leave as a one-cycle valid pulse with both words. Configuration inputs are expected to change only while reset is asserted.

Top module: `audio_sport_master`

## Requirements
- R1: While `rst_ni` is low, `bck_o`, `mclk_o`, `tx_ready_o`, `rx_valid_o` and `underrun_o` are 0, `rx_left_o` is 0, and the frame position is 0.
- R2: Each `bck_o` half-period lasts max(`cfg_div_i`, 3) system cycles. After reset, `bck_o` starts with a low half.
- R3: A frame holds 32 bit periods when `cfg_wide_i` = 0 and 64 when it is 1. The frame clock repeats once per frame.
- R4: Frame clock levels by `cfg_fmt_i`. Code 0 (I2S) is low in the first half and high in the second. Codes 1 (left-justified), 2 (right-justified) and 3 (long sync) are high in the first half and low in the second. Code 4 (short sync) is high only in bit period 0. Codes 5 to 7 behave as code 0.
- R5: Data is sent MSB first; the left word occupies the first half-frame and the right word the second. I2S data starts one bit period after the half-frame begins; all other formats start at bit 0 of the half. In a 64-period frame each half holds 24 data bits, followed by 8 zero bits in modes 0, 1, 3 and 4. Right-justified puts the 8 zero bits first. In a 32-period frame each half carries the upper 16 bits of the sample.
- R6: `sdo_o` and `lrck_o` change only in the cycle that follows a falling `bck_o` edge.
- R7: `sdi_i` is sampled on each rising `bck_o` edge and placed into the received pair with the same bit map as R5. Positions that carry no data read as 0.
- R8: `rx_valid_o` pulses for one cycle, right after the rising edge of the last bit period of a frame's data map. In I2S that edge falls in bit period 0 of the next frame. The pulse presents the pair captured up to and including that bit.
- R9: `tx_ready_o` is high for exactly one cycle per frame. That cycle is the one before the falling edge that starts the first left-word slot (bit period 1 in I2S, 0 otherwise). A pair is taken when `tx_valid_i` is high in that cycle.
- R10: If `tx_valid_i` is low while `tx_ready_o` is high, the frame sends an all-zero pair and `underrun_o` goes high and stays high until reset.
- R11: `mclk_o` toggles on every system clock edge, giving half the system clock rate.
- R12: The held transmit pair resets to zero. Bit periods sent before the first transfer carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fmt_i | input | 3 | Framing format code |
| cfg_wide_i | input | 1 | 0: 32 bit periods per frame, 1: 64 |
| cfg_div_i | input | DIV_W | Bit-clock half-period in system cycles (min 3) |
| tx_valid_i | input | 1 | Transmit pair valid |
| tx_left_i | input | 24 | Left transmit sample |
| tx_right_i | input | 24 | Right transmit sample |
| tx_ready_o | output | 1 | Transmit pair taken this cycle if valid |
| sdi_i | input | 1 | Serial data in |
| rx_valid_o | output | 1 | Received pair valid (one cycle) |
| rx_left_o | output | 24 | Left received sample |
| rx_right_o | output | 24 | Right received sample |
| mclk_o | output | 1 | Master clock, system clock / 2 |
| bck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| sdo_o | output | 1 | Serial data out |
| underrun_o | output | 1 | Sticky transmit underrun flag |

## Verification
Every result follows from the number of clock edges counted since reset. `bck_o` toggles on the edge that completes each half-period. `sdo_o` and `lrck_o` settle in the same cycle as the falling edge that moves the position on. `rx_valid_o` and the received pair appear in the cycle right after the rising edge that captured the last mapped bit. `tx_ready_o` depends only on state, so it is due in the cycle before the loading edge. The bench steps a behavioural model once per edge, using the same inputs the design sees, and compares every output on the following falling system-clock edge, half a cycle away from the active edge.

// File: rtl/audio_sport_pkg.sv
package audio_sport_pkg;
  localparam int SAMPLE_W = 24;
  localparam int POS_W    = 6;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_RJ    = 3'd2,
    FMT_LONG  = 3'd3,
    FMT_SHORT = 3'd4
  } fmt_e;

  typedef struct packed {
    logic       right;
    logic       valid;
    logic       last;
    logic [4:0] bitk;   // MSB-first index inside the word
  } slot_t;

  function automatic fmt_e norm_fmt(logic [2:0] f);
    return (f > 3'd4) ? FMT_I2S : fmt_e'(f);
  endfunction

  function automatic slot_t slot_decode(fmt_e f, logic wide, logic [POS_W-1:0] pos);
    slot_t      r;
    logic [5:0] s;
    logic [4:0] q, pad, lim;
    s = pos - ((f == FMT_I2S) ? 6'd1 : 6'd0);
    if (!wide) s[5] = 1'b0;
    r.right = wide ? s[5] : s[4];
    q       = wide ? s[4:0] : {1'b0, s[3:0]};
    pad     = (f == FMT_RJ && wide) ? 5'(32 - SAMPLE_W) : 5'd0;
    lim     = wide ? 5'(SAMPLE_W) : 5'd16;
    r.valid = (q >= pad) && ((q - pad) < lim);
    r.last  = wide ? (s == 6'd63) : (s[4:0] == 5'd31);
    r.bitk  = q - pad;
    return r;
  endfunction

  function automatic logic frame_level(fmt_e f, logic wide, logic [POS_W-1:0] pos);
    logic second;
    second = wide ? pos[5] : pos[4];
    case (f)
      FMT_I2S:   return second;
      FMT_SHORT: return (pos == '0);
      default:   return ~second;
    endcase
  endfunction
endpackage

// File: rtl/asp_bitclk_gen.sv
module asp_bitclk_gen
  import audio_sport_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] half_i,
  input  logic             wide_i,
  output logic             bck_o,
  output logic             mclk_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] next_pos_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(3);

  logic [DIV_W-1:0] half_eff, cnt_q;
  logic [POS_W-1:0] pos_q, last_pos;
  logic             bck_q, mclk_q, tick;

  assign half_eff   = (half_i < MIN_HALF) ? MIN_HALF : half_i;
  assign tick       = (cnt_q == half_eff - DIV_W'(1));
  assign last_pos   = wide_i ? POS_W'(63) : POS_W'(31);
  assign next_pos_o = (pos_q == last_pos) ? '0 : pos_q + POS_W'(1);
  assign rise_o     = tick & ~bck_q;
  assign fall_o     = tick & bck_q;
  assign bck_o      = bck_q;
  assign mclk_o     = mclk_q;
  assign pos_o      = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bck_q  <= 1'b0;
      mclk_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      mclk_q <= ~mclk_q;
      cnt_q  <= tick ? '0 : cnt_q + DIV_W'(1);
      if (tick) bck_q <= ~bck_q;
      if (fall_o) pos_q <= next_pos_o;
    end
  end

  // R2: each half of the bit clock spans at least three system cycles
  a_r2_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bck_o) |-> ($past(bck_o, 2) && $past(bck_o, 3)));
  a_r2_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bck_o) |-> (!$past(bck_o, 2) && !$past(bck_o, 3)));
endmodule

// File: rtl/asp_tx_frame.sv
module asp_tx_frame
  import audio_sport_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic                wide_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic [POS_W-1:0]    next_pos_i,
  input  logic                fall_i,
  input  logic                bck_i,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                tx_ready_o,
  output logic                sdo_o,
  output logic                lrck_o,
  output logic                underrun_o
);
  logic [SAMPLE_W-1:0] cur_l_q, cur_r_q;
  logic [POS_W-1:0]    load_pos;
  logic [4:0]          idx;
  logic                und_q;
  slot_t               sl;

  // pair is loaded on the falling edge that opens the first left data slot
  assign load_pos   = (fmt_i == FMT_I2S) ? POS_W'(1) : '0;
  assign tx_ready_o = fall_i && (next_pos_i == load_pos);

  assign sl     = slot_decode(fmt_i, wide_i, pos_i);
  assign idx    = 5'(SAMPLE_W - 1) - sl.bitk;
  assign sdo_o  = sl.valid ? (sl.right ? cur_r_q[idx] : cur_l_q[idx]) : 1'b0;
  assign lrck_o = frame_level(fmt_i, wide_i, pos_i);
  assign underrun_o = und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_l_q <= '0;
      cur_r_q <= '0;
      und_q   <= 1'b0;
    end else if (tx_ready_o) begin
      if (tx_valid_i) begin
        cur_l_q <= tx_left_i;
        cur_r_q <= tx_right_i;
      end else begin
        cur_l_q <= '0;
        cur_r_q <= '0;
        und_q   <= 1'b1;
      end
    end
  end

  a_r9_ready_before_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> $fell(bck_i));
  a_r10_underrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> underrun_o);
  a_r10_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
  a_r6_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(fall_i));
  a_r6_lrck_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrck_o) |-> $past(fall_i));
endmodule

// File: rtl/asp_rx_frame.sv
module asp_rx_frame
  import audio_sport_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic                wide_i,
  input  logic [POS_W-1:0]    pos_i,
  input  logic                rise_i,
  input  logic                sdi_i,
  output logic                rx_valid_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o
);
  logic [SAMPLE_W-1:0] work_l_q, work_r_q, work_l_n, work_r_n;
  logic [4:0]          idx;
  logic                emit;
  slot_t               sl;

  assign sl   = slot_decode(fmt_i, wide_i, pos_i);
  assign idx  = 5'(SAMPLE_W - 1) - sl.bitk;
  assign emit = rise_i && sl.last;

  always_comb begin
    work_l_n = work_l_q;
    work_r_n = work_r_q;
    if (rise_i && sl.valid) begin
      if (sl.right) work_r_n[idx] = sdi_i;
      else          work_l_n[idx] = sdi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_l_q   <= '0;
      work_r_q   <= '0;
      rx_left_o  <= '0;
      rx_right_o <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= emit;
      if (emit) begin
        rx_left_o  <= work_l_n;
        rx_right_o <= work_r_n;
        work_l_q   <= '0;
        work_r_q   <= '0;
      end else begin
        work_l_q <= work_l_n;
        work_r_q <= work_r_n;
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r8_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rise_i));
endmodule

// File: rtl/audio_sport_master.sv
module audio_sport_master
  import audio_sport_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          cfg_fmt_i,
  input  logic                cfg_wide_i,
  input  logic [DIV_W-1:0]    cfg_div_i,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                tx_ready_o,
  input  logic                sdi_i,
  output logic                rx_valid_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic                mclk_o,
  output logic                bck_o,
  output logic                lrck_o,
  output logic                sdo_o,
  output logic                underrun_o
);
  fmt_e             fmt;
  logic [POS_W-1:0] pos, next_pos;
  logic             rise, fall;

  assign fmt = norm_fmt(cfg_fmt_i);

  asp_bitclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_i     (cfg_div_i),
    .wide_i     (cfg_wide_i),
    .bck_o      (bck_o),
    .mclk_o     (mclk_o),
    .pos_o      (pos),
    .next_pos_o (next_pos),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  asp_tx_frame u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt),
    .wide_i     (cfg_wide_i),
    .pos_i      (pos),
    .next_pos_i (next_pos),
    .fall_i     (fall),
    .bck_i      (bck_o),
    .tx_valid_i (tx_valid_i),
    .tx_left_i  (tx_left_i),
    .tx_right_i (tx_right_i),
    .tx_ready_o (tx_ready_o),
    .sdo_o      (sdo_o),
    .lrck_o     (lrck_o),
    .underrun_o (underrun_o)
  );

  asp_rx_frame u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt),
    .wide_i     (cfg_wide_i),
    .pos_i      (pos),
    .rise_i     (rise),
    .sdi_i      (sdi_i),
    .rx_valid_o (rx_valid_o),
    .rx_left_o  (rx_left_o),
    .rx_right_o (rx_right_o)
  );
endmodule

// File: tb/tb_audio_sport_master.sv
`timescale 1ns/1ps
module tb_audio_sport_master;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cfg_fmt = '0;
  logic        cfg_wide = 1'b0;
  logic [7:0]  cfg_div = 8'd3;
  logic        tx_valid = 1'b0;
  logic [23:0] tx_l = '0, tx_r = '0;
  logic        sdi = 1'b0;
  logic        tx_ready, rx_valid, mclk, bck, lrck, sdo, underrun;
  logic [23:0] rx_l, rx_r;

  int errors = 0, checks = 0;
  bit done = 0;

  // behavioural model state
  int m_e, m_half, m_n, m_h, m_fmt, m_delay, m_lc, m_k;
  logic [23:0] m_l, m_r, m_wl, m_wr, m_rxl, m_rxr;
  bit m_rxv, m_und, m_mclk, m_zero;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  audio_sport_master dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_fmt_i(cfg_fmt), .cfg_wide_i(cfg_wide),
    .cfg_div_i(cfg_div), .tx_valid_i(tx_valid), .tx_left_i(tx_l), .tx_right_i(tx_r),
    .tx_ready_o(tx_ready), .sdi_i(sdi), .rx_valid_o(rx_valid), .rx_left_o(rx_l),
    .rx_right_o(rx_r), .mclk_o(mclk), .bck_o(bck), .lrck_o(lrck), .sdo_o(sdo),
    .underrun_o(underrun)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [23:0] tx_word(int k, int side);
    return 24'((k * 1234567) + (side * 7654321) + 'hA5C3E1);
  endfunction

  function automatic void slot_ref(input int p, output int rt, output int vl,
                                   output int bk, output int ls);
    int s, q, pad, w;
    s   = (p - m_delay + m_n) % m_n;
    rt  = (s >= m_h);
    q   = s % m_h;
    pad = (m_fmt == 2 && m_n == 64) ? 8 : 0;
    w   = (m_n == 64) ? 24 : 16;
    vl  = (q >= pad && q - pad < w);
    bk  = q - pad;
    ls  = (s == m_n - 1);
  endfunction

  function automatic bit lrck_ref(int p);
    if (m_fmt == 0) return p >= m_h;
    if (m_fmt == 4) return p == 0;
    return p < m_h;
  endfunction

  task automatic drive(int drop);
    tx_valid = (m_lc != drop);
    tx_l = tx_word(m_k, 0);
    tx_r = tx_word(m_k, 1);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    sdi = lf[0];
  endtask

  // advances the model across the next rising system-clock edge
  task automatic step();
    int en, hp, p, rt, vl, bk, ls;
    logic [23:0] wl, wr;
    m_rxv = 0;
    en = m_e + 1;
    if (en % m_half == 0) begin
      hp = en / m_half;
      p  = (hp / 2) % m_n;
      if (hp % 2 == 1) begin
        slot_ref(p, rt, vl, bk, ls);
        wl = m_wl; wr = m_wr;
        if (vl != 0) begin
          if (rt != 0) wr[23 - bk] = sdi;
          else         wl[23 - bk] = sdi;
        end
        if (ls != 0) begin
          m_rxl = wl; m_rxr = wr; m_rxv = 1; wl = '0; wr = '0;
        end
        m_wl = wl; m_wr = wr;
      end else if (p == m_delay) begin
        if (tx_valid) begin
          m_l = tx_l; m_r = tx_r; m_k++; m_zero = 0;
        end else begin
          m_l = '0; m_r = '0; m_und = 1; m_zero = 1;
        end
        m_lc++;
      end
    end
    m_mclk = ~m_mclk;
    m_e = en;
  endtask

  task automatic compare();
    int hp, p, rt, vl, bk, ls, en;
    bit exp_sdo, rdy;
    string tag;
    hp = m_e / m_half;
    p  = (hp / 2) % m_n;
    chk(bck == bit'(hp % 2), "R2 bck", bck, hp % 2);
    chk(lrck == lrck_ref(p), "R3 R4 lrck", lrck, lrck_ref(p));
    slot_ref(p, rt, vl, bk, ls);
    exp_sdo = (vl != 0) ? ((rt != 0) ? m_r[23 - bk] : m_l[23 - bk]) : 1'b0;
    tag = (m_lc == 0) ? "R12 sdo before first transfer" :
          (m_zero ? "R10 zeroed pair sdo" : "R5 R6 sdo");
    chk(sdo == exp_sdo, tag, sdo, exp_sdo);
    chk(mclk == m_mclk, "R11 mclk", mclk, m_mclk);
    en  = m_e + 1;
    rdy = (en % m_half == 0) && ((en / m_half) % 2 == 0) && (((en / m_half) / 2) % m_n == m_delay);
    chk(tx_ready == rdy, "R9 tx_ready", tx_ready, rdy);
    chk(underrun == m_und, "R10 underrun", underrun, m_und);
    chk(rx_valid == m_rxv, "R8 rx_valid", rx_valid, m_rxv);
    if (m_rxv) begin
      chk(rx_l == m_rxl, "R7 rx_left", rx_l, m_rxl);
      chk(rx_r == m_rxr, "R7 rx_right", rx_r, m_rxr);
    end
  endtask

  task automatic run_cfg(int fmt, int wide, int div, int drop);
    int cycles;
    rst_ni   = 1'b0;
    cfg_fmt  = 3'(fmt);
    cfg_wide = wide[0];
    cfg_div  = 8'(div);
    m_fmt = (fmt > 4) ? 0 : fmt;
    m_delay = (m_fmt == 0) ? 1 : 0;
    m_half = (div < 3) ? 3 : div;
    m_n = wide ? 64 : 32;
    m_h = m_n / 2;
    m_e = 0; m_lc = 0; m_k = 0;
    m_l = '0; m_r = '0; m_wl = '0; m_wr = '0; m_rxl = '0; m_rxr = '0;
    m_rxv = 0; m_und = 0; m_mclk = 0; m_zero = 0;
    tx_valid = 1'b1; tx_l = tx_word(0, 0); tx_r = tx_word(0, 1); sdi = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bck == 1'b0, "R1 bck", bck, 0);
    chk(mclk == 1'b0, "R1 mclk", mclk, 0);
    chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(underrun == 1'b0, "R1 underrun", underrun, 0);
    chk(rx_l == '0, "R1 rx_left", rx_l, 0);
    chk(lrck == lrck_ref(0), "R1 lrck at position 0", lrck, lrck_ref(0));
    rst_ni = 1'b1;
    drive(drop);
    step();
    cycles = 3 * m_n * 2 * m_half;
    repeat (cycles) begin
      @(negedge clk);
      compare();
      drive(drop);
      step();
    end
  endtask

  initial begin
    for (int f = 0; f < 5; f++) run_cfg(f, 1, 3, -1);
    for (int f = 0; f < 5; f++) run_cfg(f, 0, 3, -1);
    run_cfg(6, 1, 4, -1);   // reserved code behaves as I2S (R4)
    run_cfg(2, 1, 1, 1);    // divider floor (R2) and underrun (R10)
    run_cfg(0, 0, 5, 2);    // I2S narrow with underrun (R10)
    run_cfg(3, 1, 7, -1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule